// File: doc/BRIEF.md
# Iterative Non-Restoring Integer Divider

This block divides a 32-bit dividend by a 32-bit divisor over several clock cycles and returns both the quotient and the remainder. Both operands are treated as two's-complement numbers or both as unsigned ones, depending on a mode input that is sampled with the start pulse. Inside the unit, the add/subtract loop of the non-restoring method works only on magnitudes. Signs are removed in a fixed first cycle and put back in an optional last cycle.

Each operation runs through the same stages in order. First comes one operand adjust cycle that takes magnitudes. Then come 8, 16, 24 or 32 add/subtract iterations. The first iteration also checks how many leading bytes of the dividend magnitude are zero, and that check sets the iteration count. After the loop there is one remainder correction cycle, which is always spent. A sign correction cycle follows only for signed operations that have a negative operand. The latency therefore depends only on the operands. A new operation can be started while the previous one is in its final cycle, so its adjust cycle overlaps the write of the previous result.

Top module: `nr_divider`

## Requirements
- R1: After reset, `busy` and `done` are low.
- R2: With `is_signed` low, `quotient` is the floor of dividend/divisor and `remainder` is dividend minus quotient times divisor, for every nonzero divisor.
- R3: With `is_signed` high, the quotient magnitude is |dividend|/|divisor| rounded toward zero. The quotient is negative when the operand signs differ, and the remainder takes the sign of the dividend. All results are kept to 32 bits, so the most negative value divided by -1 gives 0x80000000 with remainder 0.
- R4: The iteration count n is 8 when the top 24 bits of the dividend magnitude are zero, 16 when only the top 16 bits are zero, 24 when only the top 8 bits are zero, and 32 otherwise. A zero dividend uses n = 8.
- R5: `done` rises exactly L clock edges after the edge that accepts `start`. L is n+2, plus 1 when `is_signed` is high and either operand has bit 31 set. This gives 11, 19, 27 or 35 cycles with sign correction, and one less without it.
- R6: `busy` is high from the edge that accepts `start` until the operation reaches its final stage cycle, and it is low in that final cycle. `start` is accepted exactly when `busy` is low.
- R7: A `start` given while `busy` is high is ignored. The running operation's result and latency do not change.
- R8: A `start` given during the final stage cycle is accepted. The earlier result appears with `done` on that same edge, and the new operation completes after its own latency L.
- R9: `done` is a single-cycle pulse. `quotient` and `remainder` keep their values until the next `done`.
- R10: A zero divisor does not stall the unit. The operation completes with the same latency as R5, and the result values are unspecified.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division; sampled with the operands |
| is_signed | input | 1 | 1: two's-complement operands, 0: unsigned |
| dividend | input | 32 | Dividend |
| divisor | input | 32 | Divisor |
| busy | output | 1 | High while a new start would be ignored |
| done | output | 1 | One-cycle pulse when results are updated |
| quotient | output | 32 | Quotient of the last completed division |
| remainder | output | 32 | Remainder of the last completed division |

## Verification
For every operation, the bench computes from the operands how many edges after the accepting edge `done` should appear: the iteration count from the dividend's leading zero bytes, plus two, plus one when sign correction applies. It counts cycles at falling edges after the accepting edge and compares the count at which `done` is first seen with that figure. It then reads the quotient and remainder in the same half-cycle. In back-to-back runs, the bench drives the next start in the first cycle where `busy` reads low. It expects the previous result on the edge that accepts the new start, and it then measures the new operation's latency from that same edge.

// File: rtl/nr_div_pkg.sv
package nr_div_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_OPADJ = 3'd1,
    ST_ITER = 3'd2,
    ST_REMFIX = 3'd3,
    ST_SGNFIX = 3'd4
  } div_state_e;
endpackage

// File: rtl/nr_div_early_in.sv
// Leading-zero-group detector: decides how many of the top groups of the
// dividend magnitude are zero, yielding a pre-shift and iteration count.
module nr_div_early_in #(
  parameter int W = 32,
  parameter int G = 8,
  localparam int NG = W / G,
  localparam int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  mag,
  output logic [CW-1:0] shamt,
  output logic [CW-1:0] iters
);
  int unsigned zgrp;
  logic        hit;

  always_comb begin
    zgrp = 0;
    hit  = 1'b0;
    for (int i = NG - 1; i >= 1; i--) begin
      if (!hit && (mag[i*G +: G] == '0)) zgrp = zgrp + 1;
      else hit = 1'b1;
    end
    shamt = CW'(zgrp * G);
    iters = CW'(W - zgrp * G);
  end
endmodule

// File: rtl/nr_div_step.sv
// One non-restoring add/subtract step on a (W+2)-bit signed partial remainder.
module nr_div_step #(
  parameter int W = 32
) (
  input  logic [W+1:0] rem_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] dsr,
  output logic [W+1:0] rem_o,
  output logic [W-1:0] q_o
);
  logic [W+1:0] shifted;
  logic [W+1:0] dext;

  always_comb begin
    shifted = {rem_i[W:0], q_i[W-1]};
    dext    = {2'b00, dsr};
    if (rem_i[W+1]) rem_o = shifted + dext;
    else            rem_o = shifted - dext;
    q_o = {q_i[W-2:0], ~rem_o[W+1]};
  end
endmodule

// File: rtl/nr_divider.sv
module nr_divider
  import nr_div_pkg::*;
#(
  parameter int W = 32,
  parameter int G = 8,
  localparam int CW = $clog2(W + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  div_state_e   st_q, st_d;
  logic [W-1:0] opa_q, opa_d, opb_q, opb_d;
  logic         sgn_q, sgn_d;
  logic [W-1:0] quo_q, quo_d, dsr_q, dsr_d;
  logic [W+1:0] rem_q, rem_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic         first_q, first_d;
  logic         fixs_q, fixs_d, negq_q, negq_d, negr_q, negr_d;
  logic         done_d;
  logic [W-1:0] qout_d, rout_d;

  logic [W-1:0]  mag_a, mag_b, q_src;
  logic [CW-1:0] ei_shamt, ei_iters, left;
  logic [W+1:0]  st_rem;
  logic [W-1:0]  st_q_o;
  logic [W+1:0]  rem_fix;
  logic          last_stage, accept;

  nr_div_early_in #(.W(W), .G(G)) u_early (
    .mag(quo_q), .shamt(ei_shamt), .iters(ei_iters)
  );

  assign q_src = first_q ? (quo_q << ei_shamt) : quo_q;
  assign left  = first_q ? ei_iters : cnt_q;

  nr_div_step #(.W(W)) u_step (
    .rem_i(rem_q), .q_i(q_src), .dsr(dsr_q), .rem_o(st_rem), .q_o(st_q_o)
  );

  assign mag_a   = (sgn_q && opa_q[W-1]) ? (~opa_q + 1'b1) : opa_q;
  assign mag_b   = (sgn_q && opb_q[W-1]) ? (~opb_q + 1'b1) : opb_q;
  assign rem_fix = rem_q[W+1] ? (rem_q + {2'b00, dsr_q}) : rem_q;

  assign last_stage = ((st_q == ST_REMFIX) && !fixs_q) || (st_q == ST_SGNFIX);
  assign busy       = (st_q != ST_IDLE) && !last_stage;
  assign accept     = start && !busy;

  always_comb begin
    st_d    = st_q;
    opa_d   = opa_q;
    opb_d   = opb_q;
    sgn_d   = sgn_q;
    quo_d   = quo_q;
    dsr_d   = dsr_q;
    rem_d   = rem_q;
    cnt_d   = cnt_q;
    first_d = first_q;
    fixs_d  = fixs_q;
    negq_d  = negq_q;
    negr_d  = negr_q;
    done_d  = 1'b0;
    qout_d  = quotient;
    rout_d  = remainder;
    case (st_q)
      ST_OPADJ: begin
        quo_d   = mag_a;
        dsr_d   = mag_b;
        rem_d   = '0;
        first_d = 1'b1;
        fixs_d  = sgn_q && (opa_q[W-1] || opb_q[W-1]);
        negq_d  = sgn_q && (opa_q[W-1] ^ opb_q[W-1]);
        negr_d  = sgn_q && opa_q[W-1];
        st_d    = ST_ITER;
      end
      ST_ITER: begin
        rem_d   = st_rem;
        quo_d   = st_q_o;
        first_d = 1'b0;
        cnt_d   = left - 1'b1;
        if (left == CW'(1)) st_d = ST_REMFIX;
      end
      ST_REMFIX: begin
        if (fixs_q) begin
          rem_d = rem_fix;
          st_d  = ST_SGNFIX;
        end else begin
          qout_d = quo_q;
          rout_d = rem_fix[W-1:0];
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      ST_SGNFIX: begin
        qout_d = negq_q ? (~quo_q + 1'b1) : quo_q;
        rout_d = negr_q ? (~rem_q[W-1:0] + 1'b1) : rem_q[W-1:0];
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: ;
    endcase
    if (accept) begin
      opa_d = dividend;
      opb_d = divisor;
      sgn_d = is_signed;
      st_d  = ST_OPADJ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      opa_q     <= '0;
      opb_q     <= '0;
      sgn_q     <= 1'b0;
      quo_q     <= '0;
      dsr_q     <= '0;
      rem_q     <= '0;
      cnt_q     <= '0;
      first_q   <= 1'b0;
      fixs_q    <= 1'b0;
      negq_q    <= 1'b0;
      negr_q    <= 1'b0;
      done      <= 1'b0;
      quotient  <= '0;
      remainder <= '0;
    end else begin
      st_q      <= st_d;
      opa_q     <= opa_d;
      opb_q     <= opb_d;
      sgn_q     <= sgn_d;
      quo_q     <= quo_d;
      dsr_q     <= dsr_d;
      rem_q     <= rem_d;
      cnt_q     <= cnt_d;
      first_q   <= first_d;
      fixs_q    <= fixs_d;
      negq_q    <= negq_d;
      negr_q    <= negr_d;
      done      <= done_d;
      quotient  <= qout_d;
      remainder <= rout_d;
    end
  end

  // Assertion-only counter of consecutive iteration cycles.
  logic [CW:0] iter_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               iter_run <= '0;
    else if (st_q == ST_ITER) iter_run <= iter_run + 1'b1;
    else                      iter_run <= '0;
  end

  assert_iter_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    iter_run <= (CW+1)'(W));
  assert_iters_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ITER && first_q) |->
      (ei_iters >= CW'(G) && ei_iters <= CW'(W) && (ei_iters % G) == 0));
  assert_busy_on_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_done_after_final_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(!busy));
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_hold_outputs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder)));
endmodule

// File: tb/tb_nr_divider.sv
module tb_nr_divider;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic        is_signed;
  logic [31:0] dividend, divisor;
  logic        busy, done;
  logic [31:0] quotient, remainder;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  nr_divider dut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input logic [31:0] a, input logic [31:0] b, input logic s);
    logic [31:0] m;
    int n;
    m = (s && a[31]) ? (~a + 32'd1) : a;
    if (m[31:8] == 0)       n = 8;
    else if (m[31:16] == 0) n = 16;
    else if (m[31:24] == 0) n = 24;
    else                    n = 32;
    return n + 2 + ((s && (a[31] || b[31])) ? 1 : 0);
  endfunction

  task automatic ref_div(input logic [31:0] a, input logic [31:0] b, input logic s,
                         output logic [31:0] q, output logic [31:0] r);
    longint sa, sb;
    if (s) begin
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      q = 32'(sa / sb);
      r = 32'(sa % sb);
    end else begin
      q = a / b;
      r = a % b;
    end
  endtask

  // Count falling edges after the accepting edge until done (cycle 0 = first).
  task automatic wait_done(input logic [31:0] a, input int junk, output int cyc);
    cyc = 0;
    while (!done && cyc < 100) begin
      @(negedge clk);
      cyc++;
      if (junk != 0 && cyc == 3) begin
        start = 1'b1; dividend = ~a; divisor = 32'd7; is_signed = ~is_signed;
      end
      if (junk != 0 && cyc == 4) start = 1'b0;
    end
  endtask

  task automatic run_one(input logic [31:0] a, input logic [31:0] b, input logic s,
                         input int junk);
    int cyc;
    logic [31:0] eq, er;
    @(negedge clk);
    dividend = a; divisor = b; is_signed = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(a, junk, cyc);
    chk(junk != 0 ? "R7 latency with ignored start" :
        (b == 0 ? "R10 latency for zero divisor" : "R5 latency"),
        32'(cyc), 32'(exp_lat(a, b, s)));
    if (b != 0) begin
      ref_div(a, b, s, eq, er);
      chk(s ? "R3 quotient" : "R2 quotient", quotient, eq);
      chk(s ? "R3 remainder" : "R2 remainder", remainder, er);
      @(negedge clk);
      chk("R9 done pulse", {31'd0, done}, 32'd0);
      chk("R9 quotient held", quotient, eq);
    end
  endtask

  task automatic run_b2b(input logic [31:0] a, input logic [31:0] b, input logic s,
                         input logic [31:0] c, input logic [31:0] d, input logic t);
    int cyc;
    logic [31:0] eq, er;
    @(negedge clk);
    dividend = a; divisor = b; is_signed = s; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 100) begin @(negedge clk); cyc++; end
    chk("R6 busy low in final stage", 32'(cyc + 1), 32'(exp_lat(a, b, s)));
    dividend = c; divisor = d; is_signed = t; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ref_div(a, b, s, eq, er);
    chk("R8 first done on accept edge", {31'd0, done}, 32'd1);
    chk("R8 first quotient", quotient, eq);
    chk("R8 first remainder", remainder, er);
    chk("R6 busy after accept", {31'd0, busy}, 32'd1);
    @(negedge clk);
    cyc = 1;
    while (!done && cyc < 100) begin @(negedge clk); cyc++; end
    chk("R8 second latency", 32'(cyc), 32'(exp_lat(c, d, t)));
    ref_div(c, d, t, eq, er);
    chk("R8 second quotient", quotient, eq);
    chk("R8 second remainder", remainder, er);
  endtask

  logic [31:0] dvd_set [16] = '{32'h0, 32'h1, 32'hFF, 32'h100, 32'hFFFF, 32'h10000,
    32'hFFFFFF, 32'h1000000, 32'h7FFFFFFF, 32'h80000000, 32'hFFFFFFFF, 32'hFFFFFF01,
    32'hFFFFFF00, 32'hFFFF0000, 32'hFF000000, 32'hFEFFFFFF};
  logic [31:0] dsr_set [7] = '{32'h1, 32'h3, 32'hFFFFFFFF, 32'hFFFFFFFD, 32'h10,
    32'h7FFFFFFF, 32'h80000000};

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; is_signed = 1'b0; dividend = '0; divisor = '0;
    repeat (3) @(negedge clk);
    chk("R1 busy at reset", {31'd0, busy}, 32'd0);
    chk("R1 done at reset", {31'd0, done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy after release", {31'd0, busy}, 32'd0);

    // R4/R5 early-in boundaries across all sign combinations and both modes
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 7; j++)
        for (int m = 0; m < 2; m++)
          run_one(dvd_set[i], dsr_set[j], m[0], 0);

    // R2/R3 random operands with varied magnitudes
    for (int k = 0; k < 300; k++) begin
      logic [31:0] a, b;
      a = $urandom() >> ($urandom() % 32);
      b = $urandom() >> ($urandom() % 32);
      if ($urandom() % 2 == 1) a = ~a + 32'd1;
      if ($urandom() % 2 == 1) b = ~b + 32'd1;
      if (b == 0) b = 32'd5;
      run_one(a, b, k[0], 0);
    end

    // R10 zero divisor
    run_one(32'h12345, 32'h0, 1'b0, 0);
    run_one(32'h80000000, 32'h0, 1'b1, 0);
    // R7 start while busy ignored
    run_one(32'h00ABCDEF, 32'h00000123, 1'b0, 1);
    run_one(32'hF0000001, 32'h00000007, 1'b1, 1);
    // R8 back-to-back issue
    run_b2b(32'h000000C8, 32'h7, 1'b0, 32'hFFFFF000, 32'hFFFFFFF3, 1'b1);
    run_b2b(32'h80000000, 32'hFFFFFFFF, 1'b1, 32'h00001234, 32'h11, 1'b1);
    run_b2b(32'hDEADBEEF, 32'h1000, 1'b0, 32'h7F, 32'h2, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule